// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Decoder

This block guards a 32-bit memory word with seven check bits, forming a 39-bit codeword. On the write side it turns a data word into a full codeword, ready to be stored. On the read side it takes a codeword as it comes back from storage. It forms an 8-bit syndrome, repairs any single flipped bit in either the data or the check bits, and presents the repaired data word without a clock delay.

Each read is qualified by a strobe. One clock after the strobe, the block raises a one-cycle pulse: one for a repaired error, another for an error it cannot repair. At the same edge it captures the syndrome in a status register, which keeps that value until the next detected error. A read with no error leaves the status register untouched.

Codeword layout (index = Hamming position):
- Index 0 holds the overall parity bit.
- Indices 1, 2, 4, 8, 16 and 32 hold the six Hamming check bits.
- The remaining 32 indices, taken in rising order from 3 up to 38, hold data bits 31, 30, 29 and so on down to data bit 0.

Top module: `secded_word_codec`

## Requirements
- R1: `wrCode` is combinational from `wrData` and follows the index layout above. The check bit at index 2^i is the XOR of all data indices whose position has bit i set. Index 0 is chosen so that the 39 bits together hold an odd number of ones. For example, data 0x0000_0000 gives 39'h01, and data 0x8000_0000 gives 39'h0E.
- R2: Syndrome bit 0 is the XOR of all 39 read bits, so a clean word gives 1. Syndrome bits 6:1 are the Hamming parity checks over indices with the matching position bit set. Syndrome bit 7 is 0. A clean codeword therefore yields 0x01: no pulse, and `synStatus` unchanged.
- R3: A single flipped bit at index p gives syndrome `p<<1` (p = 0 gives 0x00). `corrData` then equals the original data in the same cycle, and `errCorr` pulses.
- R4: A flipped check bit (indices 0, 1, 2, 4, 8, 16, 32) is repaired without changing `corrData`, and it is reported as correctable.
- R5: Two flipped bits give syndrome bit 0 = 1 with nonzero bits 7:1. The block pulses `errUncorr`, and `corrData` carries the read data bits unmodified. `errCorr` and `errUncorr` are never high together.
- R6: Syndrome bit 0 = 0 with a position of 39 or more (which cannot be a single error) counts as uncorrectable, and the data passes through unmodified.
- R7: `synStatus` is 0 after reset. It loads the syndrome on every detected error and holds its value across all other cycles.
- R8: The pulses and the `synStatus` update appear exactly one clock after a read with `rdStrobe` high, and last one cycle. An erroneous codeword presented without the strobe causes no pulse and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 32 | Data word to encode |
| wrCode | output | 39 | Encoded codeword, index = position |
| rdCode | input | 39 | Codeword read from storage |
| rdStrobe | input | 1 | Qualifies `rdCode` as a real read |
| corrData | output | 32 | Repaired data, combinational |
| errCorr | output | 1 | One-cycle pulse: a single error was repaired |
| errUncorr | output | 1 | One-cycle pulse: an uncorrectable error was found |
| synStatus | output | 8 | Syndrome of the last detected error |

## Verification
Two things can coincide in one cycle: a capture of a new syndrome, and the pulse that reports the previous one. The bench provokes this with back-to-back strobed reads, alternating single-error and double-error codewords. Each capture must then replace the last one on the very next edge, while its own pulse type is shown. A scoreboard holds the expected pulse, syndrome and data for every driven cycle and judges each cycle on its own, so a stale or merged value shows up as a mismatch.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int unsigned DataWidth = 32;
  localparam int unsigned HamWidth  = 6;

  typedef struct packed {
    logic fixEn;
    logic captureEn;
    logic hitCorr;
    logic hitUncorr;
  } eccStrobe_t;

  // Position of the k-th data slot (k = 0 holds the top data bit):
  // the k-th index, counting upward from 3, that is not a power of two.
  function automatic int unsigned dataPos(input int unsigned k);
    int unsigned cnt;
    int unsigned res;
    bit found;
    cnt = 0;
    res = 0;
    found = 1'b0;
    for (int unsigned p = 3; p < 256; p++) begin
      if (!found && ((p & (p - 1)) != 0)) begin
        if (cnt == k) begin
          res = p;
          found = 1'b1;
        end
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = DataWidth,
  parameter int unsigned HAM_W  = HamWidth,
  localparam int unsigned CODE_W = DATA_W + HAM_W + 1,
  localparam int unsigned SYN_W  = HAM_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] rdCode,
  input  eccStrobe_t        strobes,
  output logic [SYN_W-1:0]  syndrome,
  output logic [DATA_W-1:0] corrData,
  output logic [SYN_W-1:0]  synStatus
);

  function automatic logic [CODE_W-1:0] hamMask(input int unsigned i);
    logic [CODE_W-1:0] m;
    for (int unsigned p = 0; p < CODE_W; p++) begin
      m[p] = ((p >> i) & 1) == 1;
    end
    return m;
  endfunction

  logic [CODE_W-1:0] dataOnly;
  logic [CODE_W-1:0] encCode;
  logic [HAM_W-1:0]  hamSyn;
  logic              parityBit;
  logic [CODE_W-1:0] flipVec;
  logic [CODE_W-1:0] fixedCode;

  // Write path: scatter data, add Hamming checks, then overall parity.
  always_comb begin
    dataOnly = '0;
    for (int unsigned k = 0; k < DATA_W; k++) begin
      dataOnly[dataPos(k)] = wrData[DATA_W-1-k];
    end
    encCode = dataOnly;
    for (int unsigned i = 0; i < HAM_W; i++) begin
      encCode[1 << i] = ^(dataOnly & hamMask(i));
    end
    encCode[0] = ~(^encCode);
  end

  assign wrCode = encCode;

  // Read path: syndrome.
  always_comb begin
    for (int unsigned i = 0; i < HAM_W; i++) begin
      hamSyn[i] = ^(rdCode & hamMask(i));
    end
    parityBit = ^rdCode;
  end

  assign syndrome = {1'b0, hamSyn, parityBit};

  // Correction of the indicated bit.
  always_comb begin
    for (int unsigned p = 0; p < CODE_W; p++) begin
      flipVec[p] = strobes.fixEn && (int'(hamSyn) == int'(p));
    end
    fixedCode = rdCode ^ flipVec;
  end

  generate
    for (genvar k = 0; k < DATA_W; k++) begin : g_extract
      assign corrData[DATA_W-1-k] = fixedCode[dataPos(k)];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synStatus <= '0;
    end else if (strobes.captureEn) begin
      synStatus <= syndrome;
    end
  end

endmodule

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
#(
  parameter int unsigned HAM_W  = HamWidth,
  parameter int unsigned CODE_W = DataWidth + HamWidth + 1,
  localparam int unsigned SYN_W = HAM_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStrobe,
  input  logic [SYN_W-1:0] syndrome,
  output eccStrobe_t       strobes,
  output logic             errCorr,
  output logic             errUncorr
);

  logic [SYN_W-2:0] position;
  logic             parityOk;
  logic             posInRange;
  logic             singleHit;
  logic             multiHit;

  assign position   = syndrome[SYN_W-1:1];
  assign parityOk   = syndrome[0];
  assign posInRange = int'(position) < int'(CODE_W);

  always_comb begin
    singleHit = !parityOk && posInRange;
    multiHit  = (parityOk && (position != '0)) || (!parityOk && !posInRange);
    strobes.fixEn     = singleHit;
    strobes.hitCorr   = rdStrobe && singleHit;
    strobes.hitUncorr = rdStrobe && multiHit;
    strobes.captureEn = strobes.hitCorr || strobes.hitUncorr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCorr   <= 1'b0;
      errUncorr <= 1'b0;
    end else begin
      errCorr   <= strobes.hitCorr;
      errUncorr <= strobes.hitUncorr;
    end
  end

endmodule

// File: rtl/secded_word_codec.sv
module secded_word_codec
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = DataWidth,
  parameter int unsigned HAM_W  = HamWidth,
  localparam int unsigned CODE_W = DATA_W + HAM_W + 1,
  localparam int unsigned SYN_W  = HAM_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] rdCode,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] corrData,
  output logic              errCorr,
  output logic              errUncorr,
  output logic [SYN_W-1:0]  synStatus
);

  eccStrobe_t       strobes;
  logic [SYN_W-1:0] syndrome;

  secded_datapath #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .wrCode    (wrCode),
    .rdCode    (rdCode),
    .strobes   (strobes),
    .syndrome  (syndrome),
    .corrData  (corrData),
    .synStatus (synStatus)
  );

  secded_control #(.HAM_W(HAM_W), .CODE_W(CODE_W)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .rdStrobe  (rdStrobe),
    .syndrome  (syndrome),
    .strobes   (strobes),
    .errCorr   (errCorr),
    .errUncorr (errUncorr)
  );

endmodule

// File: rtl/secded_word_codec_checker.sv
module secded_word_codec_checker #(
  parameter int unsigned CODE_W = 39,
  parameter int unsigned SYN_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdStrobe,
  input logic             errCorr,
  input logic             errUncorr,
  input logic [SYN_W-1:0] synStatus
);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(errCorr && errUncorr));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errCorr || errUncorr) |-> $past(rdStrobe));

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(errCorr || errUncorr) |-> $stable(synStatus));

  assert_corr_kind_R3: assert property (@(posedge clk) disable iff (!rstN)
    errCorr |-> (!synStatus[0] && (int'(synStatus[SYN_W-1:1]) < int'(CODE_W))));

  assert_uncorr_kind_R6: assert property (@(posedge clk) disable iff (!rstN)
    errUncorr |-> ((synStatus[0] && (synStatus[SYN_W-1:1] != '0)) ||
                   (!synStatus[0] && (int'(synStatus[SYN_W-1:1]) >= int'(CODE_W)))));

endmodule

bind secded_word_codec secded_word_codec_checker #(
  .CODE_W(CODE_W), .SYN_W(SYN_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rdStrobe  (rdStrobe),
  .errCorr   (errCorr),
  .errUncorr (errUncorr),
  .synStatus (synStatus)
);

// File: tb/secded_word_codec_tb.sv
module secded_word_codec_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          eC;
    bit          eU;
    logic [7:0]  syn;
    logic [31:0] data;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic [38:0] wrCode;
  logic [38:0] rdCode = '0;
  logic        rdStrobe = 1'b0;
  logic [31:0] corrData;
  logic        errCorr;
  logic        errUncorr;
  logic [7:0]  synStatus;

  int          nChecks = 0;
  int          nFails = 0;
  item_t       sbq[$];
  logic [7:0]  modelSyn = '0;
  int          posOf[32];

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_word_codec dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCode(wrCode),
    .rdCode(rdCode), .rdStrobe(rdStrobe), .corrData(corrData),
    .errCorr(errCorr), .errUncorr(errUncorr), .synStatus(synStatus)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [38:0] refEncode(input logic [31:0] d);
    logic [38:0] c;
    c = '0;
    for (int k = 0; k < 32; k++) c[posOf[k]] = d[31-k];
    for (int i = 0; i < 6; i++) begin
      logic b;
      b = 1'b0;
      for (int k = 0; k < 32; k++) if (((posOf[k] >> i) & 1) == 1) b ^= d[31-k];
      c[1 << i] = b;
    end
    c[0] = ~(^c[38:1]);
    return c;
  endfunction

  function automatic logic [31:0] rawData(input logic [38:0] c);
    logic [31:0] d;
    for (int k = 0; k < 32; k++) d[31-k] = c[posOf[k]];
    return d;
  endfunction

  // Scoreboard monitor: one item per driven cycle.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(errCorr == it.eC, it.tag, "errCorr", 64'(errCorr), 64'(it.eC));
      check(errUncorr == it.eU, it.tag, "errUncorr", 64'(errUncorr), 64'(it.eU));
      check(synStatus == it.syn, it.tag, "synStatus", 64'(synStatus), 64'(it.syn));
      check(corrData == it.data, it.tag, "corrData", 64'(corrData), 64'(it.data));
    end
  end

  // Drive one read cycle: data word, flipped indices, strobe.
  task automatic readCase(input logic [31:0] d, input logic [38:0] flips,
                          input bit strobe, input string tag);
    item_t it;
    logic [38:0] code;
    int cnt;
    int px;
    code = refEncode(d) ^ flips;
    cnt = $countones(flips);
    px = 0;
    for (int p = 0; p < 39; p++) if (flips[p]) px ^= p;
    it.tag = tag;
    it.eC = 1'b0;
    it.eU = 1'b0;
    it.data = d;
    if (cnt == 1) begin
      it.eC = strobe;
      if (strobe) modelSyn = 8'(px << 1);
    end else if (cnt > 1) begin
      it.eU = strobe;
      it.data = rawData(code);
      if (strobe) modelSyn = 8'((px << 1) | ((cnt % 2 == 0) ? 1 : 0));
    end
    it.syn = modelSyn;
    @(negedge clk);
    rdCode = code;
    rdStrobe = strobe;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag);
    readCase(32'h0, '0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] pats[5];
    begin
      int cnt;
      cnt = 0;
      for (int p = 3; p < 39; p++) if ((p & (p - 1)) != 0) begin
        posOf[cnt] = p;
        cnt++;
      end
    end
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    check(errCorr == 0 && errUncorr == 0, "R7", "flags in reset", 64'({errCorr, errUncorr}), 0);
    check(synStatus == 0, "R7", "synStatus in reset", 64'(synStatus), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: write path literal layout and reference encoding
    wrData = 32'h0000_0000; #1;
    check(wrCode == 39'h01, "R1", "wrCode zero", 64'(wrCode), 64'h01);
    wrData = 32'h8000_0000; #1;
    check(wrCode == 39'h0E, "R1", "wrCode top bit", 64'(wrCode), 64'h0E);
    for (int i = 0; i < 5; i++) begin
      wrData = pats[i]; #1;
      check(wrCode == refEncode(pats[i]), "R1", "wrCode pattern", 64'(wrCode), 64'(refEncode(pats[i])));
    end

    // R2: clean reads
    for (int i = 0; i < 5; i++) readCase(pats[i], '0, 1'b1, "R2");
    idle("R2");

    // R3/R4: every single-bit position, pulses last one cycle (R8)
    for (int p = 0; p < 39; p++) begin
      readCase(pats[p % 5], 39'(1) << p, 1'b1, ((p & (p - 1)) == 0) ? "R4" : "R3");
      idle("R8");
    end

    // R5: double errors, back-to-back with singles
    readCase(pats[2], (39'(1) << 3) | (39'(1) << 20), 1'b1, "R5");
    readCase(pats[3], 39'(1) << 9, 1'b1, "R3");
    readCase(pats[4], (39'(1) << 0) | (39'(1) << 38), 1'b1, "R5");
    readCase(pats[1], (39'(1) << 16) | (39'(1) << 17), 1'b1, "R5");
    idle("R8");

    // R6: triple error aliasing to position 39
    readCase(pats[3], (39'(1) << 32) | (39'(1) << 4) | (39'(1) << 3), 1'b1, "R6");
    idle("R6");

    // R8: erroneous codewords without strobe, no pulse, no capture
    readCase(pats[2], 39'(1) << 12, 1'b0, "R8");
    readCase(pats[2], (39'(1) << 5) | (39'(1) << 6), 1'b0, "R8");
    // R7: clean strobed reads keep last captured syndrome
    readCase(pats[0], '0, 1'b1, "R7");
    readCase(pats[4], 39'(1) << 25, 1'b1, "R7");
    readCase(pats[1], '0, 1'b1, "R7");
    idle("R7");
    idle("R7");

    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule